// File: doc/BRIEF.md
# Strobe-Based Bus Cycle Detector

This block is the front end of a slave that sits on an asynchronous, strobe-handshaked host bus. It watches the active-low address strobe, data strobe, chip select and read/write lines, brings them into the local clock domain, and reports where each host access begins and ends with one-clock pulses. It also drives the active-low data-transfer acknowledge back to the host. Address decoding, register access and data-bus driving are left to the logic behind it.

Access boundaries come only from strobe activity. Chip select may arrive before or after the strobes, and it may stay asserted through a run of consecutive accesses. The strobes going away and coming back separates one access from the next. The acknowledge is gated by chip select and by the access being open. It appears a fixed number of clocks after the start pulse and is withdrawn one clock after the end pulse.

Top module: `strobe_cycle_detect`

## Requirements
- R1: While reset is held and on the first cycle after it, cyc_start and cyc_end are 0 and dsack_n is 1.
- R2: A read access starts when as_n, ds_n and cs_n are all 0 and no access is open. cyc_start is 1 for exactly one clock, on the third rising edge after the pin change that completes the condition.
- R3: A write access (rw_n = 0, where rw_n = 1 means read) starts when as_n and cs_n are 0, even while ds_n is still 1. The timing is the same as R2.
- R4: The order in which the four inputs become asserted does not matter. Chip select may lead or trail the strobes, and the start follows the last required input.
- R5: An open access ends on the first strobe negation: as_n going to 1, or ds_n going to 1 after it has been 0 during the access. cyc_end is 1 for one clock, on the third rising edge after that pin change.
- R6: Only one cyc_start fires per access. After cyc_end, no new start can fire until as_n and ds_n have both been seen at 1. cyc_start and cyc_end are never 1 on the same clock.
- R7: With cs_n held at 0, a second access is started purely by the strobes negating and asserting again.
- R8: dsack_n goes to 0 on the ACK_DLY-th clock after the clock that carried cyc_start (ACK_DLY = 2 by default). It stays 0 while the access is open and chip select is asserted, and it returns to 1 on the clock after cyc_end.
- R9: If cs_n rises during an open access, dsack_n returns to 1 on the third rising edge after that change. The access still ends only as R5 says.
- R10: No access starts while cs_n is 1, whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe from host, active low, asynchronous |
| ds_n | input | 1 | Data strobe from host, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rw_n | input | 1 | 1 = read, 0 = write, asynchronous |
| cyc_start | output | 1 | One-clock pulse at access start |
| cyc_end | output | 1 | One-clock pulse at access end |
| dsack_n | output | 1 | Transfer acknowledge to host, active low |

## Verification
A pin change passes two synchronizer flops and one decision register, so a start, an end or a chip-select drop reaches the outputs on the third rising edge after it. The acknowledge falls ACK_DLY edges after the start pulse and rises one edge after the end pulse. The bench changes pins 2 ns after a rising edge. It captures them on the next edge and steps its reference model once per edge, carrying the same delays as a queue and counters. It then compares all three outputs at every falling edge, so each due value is checked in exactly the cycle where it becomes visible.

// File: rtl/scd_pkg.sv
package scd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DRAIN = 2'd2
  } cyc_state_t;

  // synchronized, active-high view of the host lines
  typedef struct packed {
    logic as;
    logic ds;
    logic cs;
    logic wr;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/scd_sync.sv
module scd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] level
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], ~pin_n[b]};
      end
      assign level[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scd_tracker.sv
module scd_tracker
  import scd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t lv,
  output logic    start_p,
  output logic    end_p,
  output logic    busy
);

  cyc_state_t st, st_nx;
  logic ds_seen, ds_seen_nx;
  logic go, stop;

  // start condition: address strobe and select, plus data strobe or write
  assign go   = lv.as && lv.cs && (lv.ds || lv.wr);
  // end condition: first strobe to fall away
  assign stop = !lv.as || (ds_seen && !lv.ds);

  always_comb begin
    st_nx      = st;
    ds_seen_nx = ds_seen;
    case (st)
      ST_IDLE: begin
        ds_seen_nx = 1'b0;
        if (go) begin
          st_nx      = ST_BUSY;
          ds_seen_nx = lv.ds;
        end
      end
      ST_BUSY: begin
        ds_seen_nx = ds_seen | lv.ds;
        if (stop) st_nx = ST_DRAIN;
      end
      ST_DRAIN: begin
        ds_seen_nx = 1'b0;
        if (!lv.as && !lv.ds) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ds_seen <= 1'b0;
      start_p <= 1'b0;
      end_p   <= 1'b0;
    end else begin
      st      <= st_nx;
      ds_seen <= ds_seen_nx;
      start_p <= (st == ST_IDLE) && go;
      end_p   <= (st == ST_BUSY) && stop;
    end
  end

  assign busy = (st == ST_BUSY);

endmodule

// File: rtl/scd_ack.sv
module scd_ack #(
  parameter int ACK_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic cs_on,
  output logic ack_n
);

  localparam int            CW   = $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_DLY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ack_n <= 1'b1;
    end else begin
      ack_n <= !(busy && (cnt == LAST) && cs_on);
      if (!busy)             cnt <= '0;
      else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/strobe_cycle_detect.sv
module strobe_cycle_detect
  import scd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_DLY     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic ds_n,
  input  logic cs_n,
  input  logic rw_n,
  output logic cyc_start,
  output logic cyc_end,
  output logic dsack_n
);

  logic [STROBE_W-1:0] lvl_bits;
  strobe_t             lvl;
  logic                busy;

  scd_sync #(.WIDTH(STROBE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin_n({as_n, ds_n, cs_n, rw_n}),
    .level(lvl_bits)
  );

  assign lvl = lvl_bits;

  scd_tracker u_trk (
    .clk    (clk),
    .rst    (rst),
    .lv     (lvl),
    .start_p(cyc_start),
    .end_p  (cyc_end),
    .busy   (busy)
  );

  scd_ack #(.ACK_DLY(ACK_DLY)) u_ack (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .cs_on(lvl.cs),
    .ack_n(dsack_n)
  );

endmodule

// File: rtl/scd_checker.sv
module scd_checker (
  input logic clk,
  input logic rst,
  input logic as_on,
  input logic ds_on,
  input logic cs_on,
  input logic cyc_start,
  input logic cyc_end,
  input logic dsack_n
);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start);

  p_start_needs_as_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> $past(as_on && cs_on));

  p_end_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    cyc_end |=> !cyc_end);

  p_end_cause_r5: assert property (@(posedge clk) disable iff (rst)
    cyc_end |-> $past(!as_on || !ds_on));

  p_not_both_r6: assert property (@(posedge clk) disable iff (rst)
    !(cyc_start && cyc_end));

  p_ack_late_r8: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> dsack_n);

  p_ack_release_r8: assert property (@(posedge clk) disable iff (rst)
    cyc_end |=> dsack_n);

  p_ack_needs_cs_r9: assert property (@(posedge clk) disable iff (rst)
    !dsack_n |-> $past(cs_on));

endmodule

bind strobe_cycle_detect scd_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .as_on    (lvl.as),
  .ds_on    (lvl.ds),
  .cs_on    (lvl.cs),
  .cyc_start(cyc_start),
  .cyc_end  (cyc_end),
  .dsack_n  (dsack_n)
);

// File: tb/sim_strobe_cycle_detect.sv
`timescale 1ns/1ps
module sim_strobe_cycle_detect;

  localparam int SYNC = 2;
  localparam int ADLY = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1, ds_n = 1'b1, cs_n = 1'b1, rw_n = 1'b1;
  logic cyc_start, cyc_end, dsack_n;

  int total = 0;
  int bad   = 0;
  int starts = 0;
  string ph = "R1";

  always #4 clk = ~clk;

  strobe_cycle_detect #(.SYNC_STAGES(SYNC), .ACK_DLY(ADLY)) u0 (
    .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .cs_n(cs_n), .rw_n(rw_n),
    .cyc_start(cyc_start), .cyc_end(cyc_end), .dsack_n(dsack_n)
  );

  // pins captured at the rising edge (they change 2 ns after it)
  logic [3:0] cap;
  logic       cap_rst;
  always @(posedge clk) begin
    cap     <= {~as_n, ~ds_n, ~cs_n, ~rw_n};
    cap_rst <= rst;
  end

  // reference model state
  logic [3:0] pipe[$];
  int  m_st = 0;
  bit  m_seen = 0;
  int  m_cnt = 0;
  bit  e_start = 0, e_end = 0, e_ack = 1;

  task automatic check(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s t=%0t actual=%b expected=%b", ph, what, $time, act, exp);
    end
  endtask

  task automatic model_step();
    logic [3:0] lv;
    bit as, ds, cs, wr, go, stop;
    int st_n, cnt_n;
    bit seen_n;
    if (cap_rst) begin
      pipe.delete();
      for (int i = 0; i < SYNC; i++) pipe.push_back(4'b0);
      m_st = 0; m_seen = 0; m_cnt = 0;
      e_start = 0; e_end = 0; e_ack = 1;
      return;
    end
    lv = pipe[0];
    as = lv[3]; ds = lv[2]; cs = lv[1]; wr = lv[0];
    go   = as && cs && (ds || wr);
    stop = !as || (m_seen && !ds);
    e_ack = !(m_st == 1 && m_cnt >= ADLY - 1 && cs);
    cnt_n = (m_st == 1) ? ((m_cnt < ADLY - 1) ? m_cnt + 1 : m_cnt) : 0;
    e_start = (m_st == 0) && go;
    e_end   = (m_st == 1) && stop;
    st_n = m_st; seen_n = 0;
    if (m_st == 0) begin
      if (go) begin st_n = 1; seen_n = ds; end
    end else if (m_st == 1) begin
      seen_n = m_seen | ds;
      if (stop) st_n = 2;
    end else begin
      if (!as && !ds) st_n = 0;
    end
    m_st = st_n; m_seen = seen_n; m_cnt = cnt_n;
    void'(pipe.pop_front());
    pipe.push_back(cap);
  endtask

  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp) begin
      model_step();
      if (!cap_rst) begin
        check("cyc_start", cyc_start, e_start);
        check("cyc_end",   cyc_end,   e_end);
        check("dsack_n",   dsack_n,   e_ack);
        if (cyc_start === 1'b1) starts++;
      end
    end
  end

  task automatic put(input logic a, input logic d, input logic c, input logic r);
    @(posedge clk); #2;
    as_n = a; ds_n = d; cs_n = c; rw_n = r;
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_starts(input int n);
    @(negedge clk); #1;
    total++;
    if (starts != n) begin
      bad++;
      $display("FAIL %s start count actual=%0d expected=%0d", ph, starts, n);
    end
    starts = 0;
  endtask

  task automatic run_all();
    run_cmp = 1;
    hold(3);
    // R1: reset state held
    @(negedge clk);
    check("reset cyc_start", cyc_start, 1'b0);
    check("reset cyc_end",   cyc_end,   1'b0);
    check("reset dsack_n",   dsack_n,   1'b1);
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk);
    check("post-reset dsack_n", dsack_n, 1'b1);
    hold(2); starts = 0;

    // R2 / R4: read, chip select leads strobes
    ph = "R2";
    put(1, 1, 0, 1); hold(2);
    put(0, 1, 0, 1); hold(1);
    put(0, 0, 0, 1); hold(10);
    ph = "R5";
    put(0, 1, 0, 1); hold(2);
    put(1, 1, 1, 1); hold(6);
    expect_starts(1);

    // R3: write starts without data strobe, ended by AS
    ph = "R3";
    put(1, 1, 0, 0); put(0, 1, 0, 0); hold(6);
    put(0, 0, 0, 0); hold(5);
    put(1, 0, 0, 0); hold(1);
    put(1, 1, 1, 1); hold(6);
    expect_starts(1);

    // R4: strobes lead, chip select last
    ph = "R4";
    put(0, 0, 1, 1); hold(5);
    put(0, 0, 0, 1); hold(8);
    put(1, 1, 1, 1); hold(6);
    expect_starts(1);

    // R7: back-to-back reads with CS held
    ph = "R7";
    put(1, 1, 0, 1);
    put(0, 0, 0, 1); hold(7);
    put(1, 1, 0, 1); hold(1);
    put(0, 0, 0, 1); hold(7);
    put(1, 1, 0, 1); hold(6);
    expect_starts(2);

    // R9: chip select drops mid-access
    ph = "R9";
    put(0, 0, 0, 1); hold(8);
    put(0, 0, 1, 1); hold(6);
    put(1, 1, 1, 1); hold(6);
    expect_starts(1);

    // R10: strobes without chip select
    ph = "R10";
    put(0, 0, 1, 1); hold(6);
    put(1, 1, 1, 1); hold(3);
    put(0, 1, 1, 0); hold(6);
    put(1, 1, 1, 1); hold(4);
    expect_starts(0);

    // R6: write ended by DS while AS held stays closed until both negate
    ph = "R6";
    put(0, 0, 0, 0); hold(7);
    put(0, 1, 0, 0); hold(10);
    expect_starts(1);
    put(1, 1, 0, 0); hold(2);
    put(0, 1, 0, 0); hold(7);
    put(1, 1, 1, 1); hold(6);
    expect_starts(1);

    // R8: short access, strobes drop right as acknowledge is due
    ph = "R8";
    put(0, 0, 0, 1); hold(3);
    put(1, 1, 0, 1); hold(8);
    expect_starts(1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired at t=%0t", $time);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule